// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus and sits in front of a 512-byte memory held inside the block as a register file. SCL and SDA reach it already synchronised to the system clock. It returns data and acknowledges through a single open-drain pull-down enable. A master can write one byte or a page of up to sixteen bytes. It can read at the current address, read at an address it gives, and read on past the end of a byte. It can also load the address pointer without reading anything. Three layers of protection decide whether a write reaches the array: a write-enable latch, a write-protect pin and an upper-half lock. A write that is accepted starts a self-timed busy window. During that window the slave does not answer its device address.

The controller is built around one state machine. `S_IDLE` ignores the bus until a start. A start from any state goes to `S_DEV`, which takes in the device byte. On a match while not busy it moves to `S_DEV_ACK`; otherwise it returns to `S_IDLE`. From `S_DEV_ACK` a write goes to `S_ADDR` and a read goes to `S_RDATA`. `S_ADDR` loads the pointer and passes through `S_ADDR_ACK` to `S_WDATA`. `S_WDATA` and `S_WDATA_ACK` alternate, one round for each data byte. `S_RDATA` shifts a byte out and passes to `S_RDATA_ACK`. There a master ACK returns to `S_RDATA` with the pointer advanced, and a NACK goes to `S_IDLE`. A stop from any state goes to `S_IDLE`. It commits the page only when it falls in `S_WDATA` right after a completed acknowledge.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the slave does not drive SDA, the write-enable latch is clear, the pointer is 000h and every array byte reads 00h.
- R2: The device byte is 1010 in bits 7..4, the DEV_SEL parameter (default 00) in bits 3..2, array address bit 8 in bit 1 and the direction in bit 0 (1 = read). The slave acknowledges by pulling SDA low during the ninth clock. If the byte does not match, the slave leaves SDA released and ignores the bus until the next start. The slave never drives SDA while the master is sending bits.
- R3: A stop that comes after at least one complete data byte and its acknowledge copies the buffered bytes into the array.
- R4: During a write the low four address bits wrap within the 16-byte page and the upper five bits stay fixed. A later byte to the same page slot replaces the earlier one. After the write the pointer holds the slot after the last byte written.
- R5: A stop that arrives part-way through a data byte writes nothing and starts no busy window.
- R6: A device write, a word address and then a stop load the pointer without writing. A following current-address read returns the byte at that address.
- R7: A device write and a word address, followed by a repeated start and a device read, return the byte at that address.
- R8: In a read the pointer advances by one after each byte the master acknowledges and wraps from 1FFh to 000h. After a master NACK the read ends and the pointer does not advance.
- R9: The write-enable latch is set by a pulse on wel_set_i and cleared by a pulse on wel_clr_i; clear wins. While it is clear no write reaches the array, but every byte is still acknowledged.
- R10: While wp_i is high no write reaches the array, but every byte is still acknowledged.
- R11: While lock_upper_i is high, writes to 100h..1FFh are discarded. Writes to 000h..0FFh still complete.
- R12: After a write that reaches the array, the slave leaves its device address unacknowledged for WR_CYCLES clocks. A discarded write starts no such window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data (bus level) |
| wp_i | input | 1 | Write-protect pin, high blocks all writes |
| lock_upper_i | input | 1 | Locks addresses 100h..1FFh against writes |
| wel_set_i | input | 1 | Pulse that sets the write-enable latch |
| wel_clr_i | input | 1 | Pulse that clears the write-enable latch |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The hardest case to reach from the ports is the exact position of a stop relative to the byte boundary. The rising SCL of the stop condition is itself taken as a data bit. A stop placed right after an acknowledge must commit. A stop placed after only a few bits of the next byte must discard every byte already buffered. The bench drives single bits by hand to place a stop three bits into a second data byte. It then probes the device address straight away, because an acknowledge there shows that no busy window started. It reads the location back as well. Page wrap and pointer wrap are reached by starting a 20-byte write four bytes below a page end and by loading the pointer with 1FFh before a two-byte read.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_ADDR,
        S_ADDR_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RDATA_ACK
    } slv_state_t;

    localparam logic [3:0] DEV_TYPE  = 4'b1010;
    localparam int         BYTE_BITS = 8;
endpackage

// File: rtl/seeprom_bus_cond.sv
module seeprom_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign rise_o  = scl_i & ~scl_q;
    assign fall_o  = ~scl_i & scl_q;
    assign start_o = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/seeprom_wr_timer.sv
module seeprom_wr_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
    end

    assign busy_o = (cnt_q != '0);

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o); // R12
endmodule

// File: rtl/seeprom_store.sv
module seeprom_store #(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     commit_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PLEN  = 1 << PAGE_W;

    logic [7:0]      mem_q [DEPTH];
    logic [7:0]      buf_q [PLEN];
    logic [PLEN-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= '0;
            vld_q <= '0;
        end else begin
            if (commit_i) begin
                for (int i = 0; i < PLEN; i++)
                    if (vld_q[i])
                        mem_q[{page_i, PAGE_W'(i)}] <= buf_q[i];
            end
            if (clr_i)
                vld_q <= '0;
            else if (buf_we_i)
                vld_q[buf_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we_i)
            buf_q[buf_idx_i] <= buf_data_i;
    end

    assign rd_data_o = mem_q[rd_addr_i];

    AST_COMMIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (vld_q != '0)); // R5
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import seeprom_pkg::*;
#(
    parameter int         ADDR_W    = 9,
    parameter int         PAGE_W    = 4,
    parameter int         WR_CYCLES = 2000,
    parameter logic [1:0] DEV_SEL   = 2'b00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic lock_upper_i,
    input  logic wel_set_i,
    input  logic wel_clr_i,
    output logic sda_oe_o
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic rise_ev, fall_ev, start_ev, stop_ev;
    logic busy;
    logic [7:0] rd_byte;

    slv_state_t        state_q, state_d;
    logic [3:0]        bit_q, bit_d;
    logic [7:0]        sh_q, sh_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic              a8_q, a8_d;
    logic              rw_q, rw_d;
    logic              mack_q, mack_d;
    logic              have_q, have_d;
    logic              wel_q;
    logic              buf_we, bus_clr, stop_ok, commit_go, addr_hit;

    seeprom_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .rise_o  (rise_ev),
        .fall_o  (fall_ev),
        .start_o (start_ev),
        .stop_o  (stop_ev)
    );

    seeprom_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (bus_clr),
        .buf_we_i   (buf_we),
        .buf_idx_i  (ptr_q[PAGE_W-1:0]),
        .buf_data_i (sh_q),
        .commit_i   (commit_go),
        .page_i     (ptr_q[ADDR_W-1:PAGE_W]),
        .rd_addr_i  (ptr_q),
        .rd_data_o  (rd_byte)
    );

    seeprom_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_go),
        .busy_o  (busy)
    );

    // write-enable latch, clear has priority
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wel_q <= 1'b0;
        else if (wel_clr_i)
            wel_q <= 1'b0;
        else if (wel_set_i)
            wel_q <= 1'b1;
    end

    assign addr_hit  = (sh_q[7:4] == DEV_TYPE) && (sh_q[3:2] == DEV_SEL);
    assign commit_go = stop_ok & wel_q & ~wp_i & ~(lock_upper_i & ptr_q[ADDR_W-1]);

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bit_q   <= '0;
            sh_q    <= '0;
            ptr_q   <= '0;
            a8_q    <= 1'b0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            have_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            sh_q    <= sh_d;
            ptr_q   <= ptr_d;
            a8_q    <= a8_d;
            rw_q    <= rw_d;
            mack_q  <= mack_d;
            have_q  <= have_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        bit_d   = bit_q;
        sh_d    = sh_q;
        ptr_d   = ptr_q;
        a8_d    = a8_q;
        rw_d    = rw_q;
        mack_d  = mack_q;
        have_d  = have_q;
        buf_we  = 1'b0;
        bus_clr = 1'b0;
        stop_ok = 1'b0;
        if (start_ev) begin
            state_d = S_DEV;
            bit_d   = '0;
            have_d  = 1'b0;
            bus_clr = 1'b1;
        end else if (stop_ev) begin
            // the stop's own SCL rise was counted as one bit
            stop_ok = (state_q == S_WDATA) && (bit_q == 4'd1) && have_q;
            state_d = S_IDLE;
            bit_d   = '0;
            have_d  = 1'b0;
            bus_clr = 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_DEV, S_ADDR, S_WDATA: begin
                    if (rise_ev) begin
                        sh_d  = {sh_q[6:0], sda_i};
                        bit_d = bit_q + 4'd1;
                    end else if (fall_ev && bit_q == 4'(BYTE_BITS)) begin
                        bit_d = '0;
                        if (state_q == S_DEV) begin
                            if (addr_hit && !busy) begin
                                state_d = S_DEV_ACK;
                                a8_d    = sh_q[1];
                                rw_d    = sh_q[0];
                            end else begin
                                state_d = S_IDLE;
                            end
                        end else if (state_q == S_ADDR) begin
                            ptr_d   = ADDR_W'({a8_q, sh_q});
                            state_d = S_ADDR_ACK;
                        end else begin
                            buf_we  = 1'b1;
                            ptr_d   = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                            state_d = S_WDATA_ACK;
                        end
                    end
                end
                S_DEV_ACK: begin
                    if (fall_ev)
                        state_d = rw_q ? S_RDATA : S_ADDR;
                end
                S_ADDR_ACK: begin
                    if (fall_ev)
                        state_d = S_WDATA;
                end
                S_WDATA_ACK: begin
                    if (fall_ev) begin
                        state_d = S_WDATA;
                        have_d  = 1'b1;
                    end
                end
                S_RDATA: begin
                    if (fall_ev) begin
                        if (bit_q == 4'(BYTE_BITS - 1)) begin
                            bit_d   = '0;
                            state_d = S_RDATA_ACK;
                        end else begin
                            bit_d = bit_q + 4'd1;
                        end
                    end
                end
                S_RDATA_ACK: begin
                    if (rise_ev)
                        mack_d = ~sda_i;
                    else if (fall_ev) begin
                        if (mack_q) begin
                            ptr_d   = ptr_q + ADDR_W'(1);
                            state_d = S_RDATA;
                        end else begin
                            state_d = S_IDLE;
                        end
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (state_q)
            S_DEV_ACK, S_ADDR_ACK, S_WDATA_ACK: sda_oe_o = 1'b1;
            S_RDATA:                            sda_oe_o = ~rd_byte[~bit_q[2:0]];
            default:                            sda_oe_o = 1'b0;
        endcase
    end

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_ev)); // R3
    AST_BUSY_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel_q)); // R9
    AST_BUSY_NEEDS_WP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i)); // R10
    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEV_ACK) |-> !busy); // R12
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WDATA_ACK) |-> (ptr_q[ADDR_W-1:PAGE_W] == $past(ptr_q[ADDR_W-1:PAGE_W]))); // R4
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RDATA && $past(state_q) == S_RDATA_ACK)
            |-> (ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)))); // R8

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: tb/test_serial_eeprom_slave.sv
`timescale 1ns/1ps
module test_serial_eeprom_slave;
    localparam int WR = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic mdrv = 1'b0;
    logic wp = 1'b0;
    logic lock = 1'b0;
    logic wset = 1'b0;
    logic wclr = 1'b0;
    logic mchk = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] mem_m [512];
    int ptr_m = 0;
    bit wel_m = 1'b0;
    logic [7:0] wq[$];

    always #2.5 clk = ~clk;
    assign sda_line = ~(mdrv | sda_oe);

    serial_eeprom_slave #(.WR_CYCLES(WR)) i_serial_eeprom_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .wp_i         (wp),
        .lock_upper_i (lock),
        .wel_set_i    (wset),
        .wel_clr_i    (wclr),
        .sda_oe_o     (sda_oe)
    );

    // every clock while the master sends a bit, the slave must stay off the line
    always @(negedge clk) begin
        if (mchk && !done) begin
            n_cmp++;
            if (sda_oe !== 1'b0) begin
                n_bad++;
                $display("FAIL R2: slave drove SDA during master bit, actual %b expected 0", sda_oe);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        mdrv = 1'b0; tick(2);
        scl = 1'b1;  tick(4);
        mdrv = 1'b1; tick(4);
        scl = 1'b0;  tick(2);
    endtask

    task automatic bus_stop();
        mdrv = 1'b1; tick(2);
        scl = 1'b1;  tick(4);
        mdrv = 1'b0; tick(4);
    endtask

    task automatic send_bit(input logic b);
        mdrv = ~b; tick(1);
        mchk = 1'b1; tick(2);
        scl = 1'b1; tick(4);
        mchk = 1'b0; scl = 1'b0; tick(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        mdrv = 1'b0; tick(3);
        scl = 1'b1; tick(2);
        ack = ~sda_line; tick(2);
        scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        mdrv = 1'b0;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            tick(3);
            scl = 1'b1; tick(2);
            v = {v[6:0], sda_line}; tick(2);
            scl = 1'b0; tick(2);
        end
        mdrv = mack; tick(3);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(1);
        mdrv = 1'b0; tick(1);
    endtask

    function automatic logic [7:0] dev(input int a, input bit rd);
        return {4'b1010, 2'b00, a[8], rd};
    endfunction

    task automatic probe(input string tag, input int exp_ack);
        logic ack;
        bus_start();
        send_byte(dev(0, 1'b0), ack);
        bus_stop();
        chk(tag, int'(ack), exp_ack);
    endtask

    task automatic wr_txn(input string tag, input int a);
        logic ack;
        logic [7:0] pb [16];
        bit pv [16];
        bit go;
        int n;
        n = wq.size();
        for (int i = 0; i < 16; i++) begin pb[i] = '0; pv[i] = 1'b0; end
        bus_start();
        send_byte(dev(a, 1'b0), ack); chk(tag, int'(ack), 1);
        send_byte(a[7:0], ack);       chk(tag, int'(ack), 1);
        ptr_m = a;
        for (int i = 0; i < n; i++) begin
            send_byte(wq[i], ack); chk(tag, int'(ack), 1);
            pb[ptr_m % 16] = wq[i];
            pv[ptr_m % 16] = 1'b1;
            ptr_m = (ptr_m & 'h1F0) | ((ptr_m + 1) & 'hF);
        end
        bus_stop();
        go = (n > 0) && wel_m && !wp && !(lock && a[8]);
        if (go)
            for (int i = 0; i < 16; i++)
                if (pv[i]) mem_m[(a & 'h1F0) | i] = pb[i];
        probe({tag, " R12 busy probe"}, go ? 0 : 1);
        if (go) tick(WR + 20);
        wq.delete();
    endtask

    task automatic rd_bytes(input string tag, input int n);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, v);
            chk(tag, int'(v), int'(mem_m[ptr_m]));
            if (i < n - 1) ptr_m = (ptr_m + 1) % 512;
        end
        bus_stop();
    endtask

    task automatic rd_random(input string tag, input int a, input int n);
        logic ack;
        bus_start();
        send_byte(dev(a, 1'b0), ack); chk(tag, int'(ack), 1);
        send_byte(a[7:0], ack);       chk(tag, int'(ack), 1);
        ptr_m = a;
        bus_start();
        send_byte(dev(0, 1'b1), ack); chk(tag, int'(ack), 1);
        rd_bytes(tag, n);
    endtask

    task automatic rd_cur(input string tag, input int n);
        logic ack;
        bus_start();
        send_byte(dev(0, 1'b1), ack); chk(tag, int'(ack), 1);
        rd_bytes(tag, n);
    endtask

    task automatic set_addr(input string tag, input int a);
        logic ack;
        bus_start();
        send_byte(dev(a, 1'b0), ack); chk(tag, int'(ack), 1);
        send_byte(a[7:0], ack);       chk(tag, int'(ack), 1);
        bus_stop();
        ptr_m = a;
    endtask

    task automatic pulse_wel(input bit set);
        if (set) wset = 1'b1; else wclr = 1'b1;
        tick(1);
        wset = 1'b0; wclr = 1'b0;
        wel_m = set;
        tick(1);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        logic ack;
        for (int i = 0; i < 512; i++) mem_m[i] = '0;
        tick(3);
        chk("R1 no drive in reset", int'(sda_oe), 0);
        rst_n = 1'b1;
        tick(4);
        chk("R1 no drive after reset", int'(sda_oe), 0);
        rd_cur("R1 pointer zero and array cleared", 1);
        rd_random("R1 array cleared", 'h1A5, 1);

        // R2 mismatching device select: no ack, bus ignored after it
        bus_start();
        send_byte(8'hA8, ack); chk("R2 wrong select nack", int'(ack), 0);
        send_byte(8'h10, ack); chk("R2 ignored until start", int'(ack), 0);
        bus_stop();

        // R9 latch clear at reset: acked but discarded
        wq.push_back(8'h55);
        wr_txn("R9 latch clear write", 'h010);
        rd_random("R9 latch clear readback", 'h010, 1);

        pulse_wel(1'b1);
        // R3 byte write
        wq.push_back(8'hA5);
        wr_txn("R3 byte write", 'h010);
        rd_random("R3 byte readback", 'h010, 1);
        rd_random("R7 random read", 'h010, 1);

        // R4 page write with wrap and overwrite
        for (int i = 0; i < 20; i++) wq.push_back(8'(8'h40 + i));
        wr_txn("R4 page wrap write", 'h0FC);
        rd_cur("R4 pointer after page write", 1);
        rd_random("R4 page contents", 'h0EF, 18);

        // R5 stop three bits into the second data byte
        bus_start();
        send_byte(dev('h020, 1'b0), ack); chk("R5 dev", int'(ack), 1);
        send_byte(8'h20, ack);            chk("R5 addr", int'(ack), 1);
        send_byte(8'h77, ack);            chk("R5 data", int'(ack), 1);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        probe("R5 no busy after abort", 1);
        rd_random("R5 nothing written", 'h020, 1);

        // page wrap inside the top page, then pointer wrap
        wq.push_back(8'h3C); wq.push_back(8'hC3);
        wr_txn("R4 top page wrap", 'h1FF);
        wq.push_back(8'h5A);
        wr_txn("R3 byte at zero", 'h000);
        set_addr("R6 set address", 'h1FF);
        rd_cur("R6 current read after set", 1);
        set_addr("R6 set address again", 'h1FF);
        rd_cur("R8 wrap 1FF to 000", 2);
        rd_cur("R8 no advance after nack", 1);
        rd_random("R8 sequential", 'h1F0, 3);

        // R10 write-protect pin
        wp = 1'b1;
        wq.push_back(8'h99);
        wr_txn("R10 wp write", 'h030);
        wp = 1'b0;
        rd_random("R10 wp readback", 'h030, 1);

        // R11 upper-half lock
        lock = 1'b1;
        wq.push_back(8'h11);
        wr_txn("R11 upper locked", 'h130);
        wq.push_back(8'h22);
        wr_txn("R11 lower open", 'h040);
        lock = 1'b0;
        rd_random("R11 upper readback", 'h130, 1);
        rd_random("R11 lower readback", 'h040, 1);

        // R9 clear pulse
        pulse_wel(1'b0);
        wq.push_back(8'h66);
        wr_txn("R9 after clear", 'h050);
        rd_random("R9 clear readback", 'h050, 1);

        tick(10);
        summary();
    end
endmodule